// File: doc/BRIEF.md
# Enhanced Configuration Write Guard

This block holds four byte-wide configuration registers of a serial port controller, plus a function register, and controls write access to the upper "enhanced" fields of those four registers. A host writes through a simple strobe, address and data bus. Bit 4 of the function register is a guard enable. While it is set, every bit of the four registers can be written. While it is clear, only the lower legacy bits take new data and the enhanced fields keep what they hold. Software sets the enable, programs the enhanced fields, then clears the enable. From then on, legacy drivers that write whole bytes to these registers cannot disturb the enhanced settings.

A two-state machine tracks the guard. GATE_LOCKED is the reset state. It moves to GATE_OPEN on the transition "unlock": a function-register write with data bit 4 at 1. GATE_OPEN returns to GATE_LOCKED on the transition "latch": a function-register write with data bit 4 at 0. Any other cycle holds the state. The protected fields drive dedicated outputs, and a combinational readback port returns any register by address.

Register map, by address: 0 interrupt-enable register (protected bits 7:4), 1 status-control register (protected bits 5:4), 2 FIFO-control register (protected bits 5:4), 3 modem-control register (protected bits 7:5), 4 function register (never protected, bit 4 is the guard enable). Addresses 5 to 7 are unmapped.

Top module: `wp_guard_top`

## Requirements
- R1: A synchronous active-high reset clears all five registers, puts the machine in GATE_LOCKED (enh_en = 0), and makes every readback value 0.
- R2: A write to address 4 always stores all 8 data bits. enh_en equals the written bit 4 from the next clock edge on (unlock when 1, latch when 0).
- R3: While enh_en is 1, a write to address 0 to 3 stores all 8 data bits. This includes the protected fields (irq_hi = bits 7:4, stat_hi = bits 5:4, fifo_hi = bits 5:4, mod_hi = bits 7:5).
- R4: While enh_en is 0, a write to address 0 to 3 leaves that register's protected field unchanged.
- R5: The unprotected bits of registers 0 to 3 are stored on every write, whatever the enh_en value. These are bits 3:0 of register 0, bits 7:6 and 3:0 of registers 1 and 2, and bits 4:0 of register 3.
- R6: Values written while enh_en is 1 are retained after a latch, and later locked writes do not change them.
- R7: rd_data is combinational and returns the register selected by rd_addr (0 to 4). Protected fields appear in their own bit positions whatever the enh_en value. Addresses 5 to 7 read as 0.
- R8: A register changes only on a clock edge where wr_en is 1 and wr_addr selects it. A write with wr_en at 0, or to addresses 5 to 7, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Readback register address |
| rd_data | output | 8 | Readback data (combinational) |
| enh_en | output | 1 | Guard enable, 1 in GATE_OPEN |
| irq_hi | output | 4 | Interrupt-enable register bits 7:4 |
| stat_hi | output | 2 | Status-control register bits 5:4 |
| fifo_hi | output | 2 | FIFO-control register bits 5:4 |
| mod_hi | output | 3 | Modem-control register bits 7:5 |

## Verification
Every register, and the guard state, takes its new value at the clock edge that samples the write. The field outputs, enh_en and rd_data therefore show a write one edge after the strobe is driven, with no further delay, because readback is purely combinational. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples 1 ns later. It compares against a byte model updated under the masks stated in the requirements. A write issued in the cycle just after an unlock or latch checks that the new guard state applies from that next edge.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int REG_W      = 8;
    localparam int NUM_REGS   = 5;
    localparam int FUNC_IDX   = 4;
    localparam int ENABLE_BIT = 4;

    typedef logic [REG_W-1:0] cfg_byte_t;

    // Per-register protection masks, indexed by register address.
    localparam cfg_byte_t GUARD_MASK [NUM_REGS] = '{
        8'hF0,   // interrupt-enable: 7:4
        8'h30,   // status-control:   5:4
        8'h30,   // FIFO-control:     5:4
        8'hE0,   // modem-control:    7:5
        8'h00    // function register: never guarded
    };

    typedef enum logic {
        GATE_LOCKED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_e;

endpackage

// File: rtl/wp_gate_fsm.sv
module wp_gate_fsm (
    input  logic clk,
    input  logic rst,
    input  logic func_wr,
    input  logic func_en_bit,
    output logic gate_open
);
    import wp_guard_pkg::*;

    gate_state_e state_q;
    gate_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: unlock / latch on function-register writes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_LOCKED: if (func_wr && func_en_bit)  state_d = GATE_OPEN;
            GATE_OPEN:   if (func_wr && !func_en_bit) state_d = GATE_LOCKED;
            default:     state_d = GATE_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        gate_open = 1'b0;
        unique case (state_q)
            GATE_LOCKED: gate_open = 1'b0;
            GATE_OPEN:   gate_open = 1'b1;
            default:     gate_open = 1'b0;
        endcase
    end

endmodule

// File: rtl/wp_field_reg.sv
module wp_field_reg
    import wp_guard_pkg::*;
#(
    parameter int        ADDR_W = 3,
    parameter int        ADDR   = 0,
    parameter cfg_byte_t MASK   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  cfg_byte_t         wr_data,
    input  logic              gate_open,
    output cfg_byte_t         q
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR);

    logic hit;
    cfg_byte_t merged;

    assign hit = wr_en && (wr_addr == MY_ADDR);

    // Guarded bits keep their value while the gate is locked.
    always_comb begin
        if (gate_open) begin
            merged = wr_data;
        end else begin
            merged = (wr_data & ~MASK) | (q & MASK);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (hit) begin
            q <= merged;
        end
    end

endmodule

// File: rtl/wp_readback.sv
module wp_readback
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  cfg_byte_t         regs [NUM_REGS],
    output cfg_byte_t         rd_data
);
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = regs[i];
            end
        end
    end

endmodule

// File: rtl/wp_guard_top.sv
module wp_guard_top
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              enh_en,
    output logic [3:0]        irq_hi,
    output logic [1:0]        stat_hi,
    output logic [1:0]        fifo_hi,
    output logic [2:0]        mod_hi
);
    localparam logic [ADDR_W-1:0] FUNC_ADDR = ADDR_W'(FUNC_IDX);

    cfg_byte_t regs_q [NUM_REGS];
    logic      gate_open;
    logic      func_wr;

    assign func_wr = wr_en && (wr_addr == FUNC_ADDR);

    wp_gate_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .func_wr     (func_wr),
        .func_en_bit (wr_data[ENABLE_BIT]),
        .gate_open   (gate_open)
    );

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        wp_field_reg #(
            .ADDR_W (ADDR_W),
            .ADDR   (i),
            .MASK   (GUARD_MASK[i])
        ) u_reg (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data),
            .gate_open (gate_open),
            .q         (regs_q[i])
        );
    end

    wp_readback #(
        .ADDR_W (ADDR_W)
    ) u_rb (
        .rd_addr (rd_addr),
        .regs    (regs_q),
        .rd_data (rd_data)
    );

    assign enh_en  = gate_open;
    assign irq_hi  = regs_q[0][7:4];
    assign stat_hi = regs_q[1][5:4];
    assign fifo_hi = regs_q[2][5:4];
    assign mod_hi  = regs_q[3][7:5];

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic              enh_en,
    input logic [3:0]        irq_hi,
    input logic [1:0]        stat_hi,
    input logic [1:0]        fifo_hi,
    input logic [2:0]        mod_hi
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!enh_en && irq_hi == '0 && stat_hi == '0 && fifo_hi == '0 && mod_hi == '0));

    // R2
    enable_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(4)) |=> (enh_en == $past(wr_data[4])));

    // R3
    open_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && enh_en && wr_addr == ADDR_W'(0)) |=> (irq_hi == $past(wr_data[7:4])));

    // R3
    open_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && enh_en && wr_addr == ADDR_W'(3)) |=> (mod_hi == $past(wr_data[7:5])));

    // R4
    locked_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !enh_en && wr_addr == ADDR_W'(0)) |=> $stable(irq_hi));

    // R4
    locked_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !enh_en && wr_addr == ADDR_W'(1)) |=> $stable(stat_hi));

    // R4
    locked_fifo_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !enh_en && wr_addr == ADDR_W'(2)) |=> $stable(fifo_hi));

    // R4
    locked_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !enh_en && wr_addr == ADDR_W'(3)) |=> $stable(mod_hi));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(irq_hi) && $stable(stat_hi) && $stable(fifo_hi)
                    && $stable(mod_hi) && $stable(enh_en)));

    // R7
    rb_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(0)) |-> (rd_data[7:4] == irq_hi));

    // R7
    rb_func_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(4)) |-> (rd_data[4] == enh_en));

    // R7
    rb_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr > ADDR_W'(4)) |-> (rd_data == 8'h00));

endmodule

bind wp_guard_top wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .enh_en  (enh_en),
    .irq_hi  (irq_hi),
    .stat_hi (stat_hi),
    .fifo_hi (fifo_hi),
    .mod_hi  (mod_hi)
);

// File: tb/test_wp_guard_top.sv
`timescale 1ns/1ps
module test_wp_guard_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       enh_en;
    logic [3:0] irq_hi;
    logic [1:0] stat_hi;
    logic [1:0] fifo_hi;
    logic [2:0] mod_hi;

    int errors = 0;
    int checks = 0;

    logic [7:0] exp_reg [5];
    logic       exp_en;
    localparam logic [7:0] MASKS [5] = '{8'hF0, 8'h30, 8'h30, 8'hE0, 8'h00};

    always #2.5 clk = ~clk;

    wp_guard_top i_wp_guard_top (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .enh_en  (enh_en),
        .irq_hi  (irq_hi),
        .stat_hi (stat_hi),
        .fifo_hi (fifo_hi),
        .mod_hi  (mod_hi)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Drive at falling edge, one rising edge, then sample 1 ns after it.
    task automatic do_write(input logic [2:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        wr_en = strobe; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (strobe && a < 3'd5) begin
            if (a == 3'd4) begin
                exp_reg[4] = d;
                exp_en     = d[4];
            end else if (exp_en) begin
                exp_reg[a] = d;
            end else begin
                exp_reg[a] = (d & ~MASKS[a]) | (exp_reg[a] & MASKS[a]);
            end
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 5; i++) begin
            rd_addr = 3'(i);
            #0.2;
            check(tag, rd_data, exp_reg[i]);
        end
        check(tag, {7'd0, enh_en}, {7'd0, exp_en});
        check(tag, {4'd0, irq_hi}, {4'd0, exp_reg[0][7:4]});
        check(tag, {6'd0, stat_hi}, {6'd0, exp_reg[1][5:4]});
        check(tag, {6'd0, fifo_hi}, {6'd0, exp_reg[2][5:4]});
        check(tag, {5'd0, mod_hi}, {5'd0, exp_reg[3][7:5]});
    endtask

    task automatic t_reset;
        for (int i = 0; i < 5; i++) exp_reg[i] = 8'h00;
        exp_en = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset state");
    endtask

    task automatic t_locked_writes;
        // R4 / R5: locked full-byte writes only reach legacy bits
        for (int i = 0; i < 4; i++) do_write(3'(i), 8'hFF, 1'b1);
        check_all("R4 R5 locked writes");
        check(8'h00 == 8'h00 ? "R4 irq field held" : "", {4'd0, irq_hi}, 8'h00);
        rd_addr = 3'd3; #0.2;
        check("R5 modem lower bits", rd_data, 8'h1F);
    endtask

    task automatic t_unlock_program;
        do_write(3'd4, 8'h10, 1'b1);      // unlock
        check("R2 unlock", {7'd0, enh_en}, 8'h01);
        do_write(3'd0, 8'hA5, 1'b1);      // first write right after unlock
        do_write(3'd1, 8'h5A, 1'b1);
        do_write(3'd2, 8'hE7, 1'b1);
        do_write(3'd3, 8'hC3, 1'b1);
        check_all("R3 open writes");
        rd_addr = 3'd0; #0.2;
        check("R3 irq full byte", rd_data, 8'hA5);
    endtask

    task automatic t_latch_and_legacy;
        do_write(3'd4, 8'hEF, 1'b1);      // latch, other bits set
        check("R2 latch", {7'd0, enh_en}, 8'h00);
        rd_addr = 3'd4; #0.2;
        check("R2 function byte", rd_data, 8'hEF);
        do_write(3'd0, 8'h00, 1'b1);
        do_write(3'd1, 8'h00, 1'b1);
        do_write(3'd2, 8'h00, 1'b1);
        do_write(3'd3, 8'h00, 1'b1);
        check_all("R6 retained after latch");
        check("R6 irq retained", {4'd0, irq_hi}, 8'h0A);
        check("R6 mod retained", {5'd0, mod_hi}, 8'h06);
    endtask

    task automatic t_no_strobe;
        do_write(3'd0, 8'h3C, 1'b0);
        do_write(3'd4, 8'h10, 1'b0);
        check_all("R8 strobe low");
        do_write(3'd5, 8'hFF, 1'b1);
        do_write(3'd7, 8'hFF, 1'b1);
        check_all("R8 unmapped write");
    endtask

    task automatic t_unmapped_read;
        for (int a = 5; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.2;
            check("R7 unmapped read", rd_data, 8'h00);
        end
    endtask

    task automatic t_reopen_change;
        do_write(3'd4, 8'h10, 1'b1);
        do_write(3'd3, 8'h1F, 1'b1);
        check("R3 reopen clears modem field", {5'd0, mod_hi}, 8'h00);
        do_write(3'd4, 8'h00, 1'b1);
        do_write(3'd3, 8'hE0, 1'b1);
        check("R4 relocked modem field", {5'd0, mod_hi}, 8'h00);
        rd_addr = 3'd3; #0.2;
        check("R5 relocked modem byte", rd_data, 8'h00);
        check_all("R6 after relock");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        t_reset();
        t_locked_writes();
        t_unlock_program();
        t_latch_and_legacy();
        t_no_strobe();
        t_unmapped_read();
        t_reopen_change();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule